// File: doc/BRIEF.md
# Interrupt Cause, Mask and Throttle Controller

This block collects interrupt causes from event sources and from software into a 32-bit cause register and drives one interrupt line toward the host. Bits [30:0] hold causes. Bit 31 mirrors the line, so the host sees the line state in the same word as the causes. A mask register, an auto-mask register and a throttle interval are loaded through a small register write port. A clear-on-read strobe returns the cause word and applies auto-masking.

Posting is throttled. When no unmasked cause is already pending, a new cause either raises the line at once or starts a timer of `interval` ticks and raises it on expiry. A tick is `TICK_DIV` clocks, which is 256 ns at the target clock. Two overrides raise the line at once: an immediate flag on the post, and the receive-overrun cause. Raising the line also folds in two external delay timers. Each one that is running is cancelled, and its cause bit is set.

Top module: `irqc_top`

## Requirements
- R1: A post with a nonzero cause vector in which any bit is already set in cause[30:0] is ignored: the cause register and the line are unchanged.
- R2: If cause[30:0] & mask[30:0] is nonzero when a post arrives, the new causes are ORed into the register and the line keeps its state.
- R3: Otherwise the causes are ORed in, and with a throttle interval of zero the line rises one clock after the post. The line always equals cause bit 31. This holds even when the posted cause is masked.
- R4: With a nonzero interval N, the line rises N×TICK_DIV clocks after the post. A post with `evt_now_i` set, or one that carries cause bit 6 (receive overrun), raises the line at once and cancels a running throttle timer. A cancelled timer never raises the line later.
- R5: Whenever the line rises, each busy delay timer gets a one-cycle pulse on `dly_cancel_o`. Busy index 0 (receive delay) sets cause bit 7. Busy index 1 (transmit delay) sets cause bit 0.
- R6: A register write with `reg_sel_i`=0 clears every cause bit, bit 31 included, that is written as 1. The line follows bit 31.
- R7: A read strobe returns the cause word as it was before the read. If the line is high, mask is ANDed with the auto-mask. If the resulting mask is zero, or the line was high with `auto_clr_en_i` set, the cause register clears to zero and the line falls.
- R8: `reg_sel_i`=2 ORs the written data into the mask, and `reg_sel_i`=3 clears the written bits of the mask. After either write the line falls if cause[30:0] & mask[30:0] is zero.
- R9: After a mask write with the line low, the line is raised (at once for interval 0, else through the throttle timer) only when an unmasked cause is pending. A mask write never raises the line with no unmasked cause.
- R10: After reset, cause, mask, auto-mask and interval are zero and the line is low.
- R11: `reg_sel_i`=1 posts the written bits [30:0] as software causes under the same rules as an event post. `reg_sel_i`=4 loads the auto-mask, and `reg_sel_i`=5 loads the interval from the low data bits.
- R12: A post with an all-zero cause vector, or a write with `reg_sel_i` 6 or 7, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Event post strobe |
| evt_cause_i | input | 31 | Causes carried by the event post |
| evt_now_i | input | 1 | Raise the line at once, bypassing the throttle |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Write target: 0 clear causes, 1 set causes, 2 mask set, 3 mask clear, 4 auto-mask, 5 interval |
| reg_wdata_i | input | 32 | Write data |
| cause_re_i | input | 1 | Clear-on-read strobe for the cause register |
| auto_clr_en_i | input | 1 | Clear the cause register on a read while the line is high |
| dly_busy_i | input | NUM_DLY | External delay timers that are running |
| dly_cancel_o | output | NUM_DLY | Cancel pulse to each busy delay timer when the line rises |
| irq_o | output | 1 | Interrupt line |
| cause_rdata_o | output | 32 | Current cause word |
| mask_o | output | 32 | Current mask |

## Verification
The bench drives a post that overlaps pending causes. A design that skipped the overlap test would OR in the new bits, or would raise the line again. It builds a pending unmasked cause with the line low, then posts again. A design that re-evaluated the line on every post would raise it there. It measures the throttle window on both sides and then cancels a running timer with an immediate post. A wrong design would fire early or late, or would raise the line again after the cancel. The bench also covers the read paths: an auto-mask that leaves the mask nonzero, auto-clear enabled, and a zero mask. Here an error would leave stale causes in the register, or would clear them when they should stay.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned IRQ_W = 32;

  typedef enum logic [2:0] {
    OP_W1C   = 3'd0,
    OP_SET   = 3'd1,
    OP_MSET  = 3'd2,
    OP_MCLR  = 3'd3,
    OP_AMASK = 3'd4,
    OP_THROT = 3'd5
  } reg_op_e;

  typedef struct packed {
    logic [IRQ_W-1:0] c;
    logic             fire;
    logic             start;
  } post_res_t;

  // One cause post against current cause/mask state
  function automatic post_res_t post_eval(
    input logic [IRQ_W-1:0] c,
    input logic [IRQ_W-1:0] m,
    input logic [IRQ_W-2:0] t,
    input logic             now,
    input logic             itv_zero
  );
    post_res_t r;
    r.c     = c;
    r.fire  = 1'b0;
    r.start = 1'b0;
    if (t == '0 || (t & c[IRQ_W-2:0]) != '0) begin
      r.c = c;
    end else if ((c[IRQ_W-2:0] & m[IRQ_W-2:0]) != '0) begin
      r.c = c | {1'b0, t};
    end else begin
      r.c = c | {1'b0, t};
      if (itv_zero || now) r.fire  = 1'b1;
      else                 r.start = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/irqc_throttle_tmr.sv
module irqc_throttle_tmr #(
  parameter int unsigned TICK_DIV = 51,
  parameter int unsigned ITV_W    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cancel_i,
  input  logic [ITV_W-1:0] interval_i,
  output logic             running_o,
  output logic             expire_o
);
  localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PW-1:0]    presc_q;
  logic [ITV_W-1:0] cnt_q;
  logic             run_q;
  logic             tick;

  assign tick      = run_q && (presc_q == PW'(TICK_DIV - 1));
  assign expire_o  = tick && (cnt_q == ITV_W'(1));
  assign running_o = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      presc_q <= '0;
      cnt_q   <= '0;
    end else if (cancel_i || expire_o) begin
      run_q   <= 1'b0;
      presc_q <= '0;
    end else if (start_i && !run_q) begin
      run_q   <= 1'b1;
      presc_q <= '0;
      cnt_q   <= interval_i;
    end else if (run_q) begin
      presc_q <= tick ? '0 : presc_q + PW'(1);
      if (tick) cnt_q <= cnt_q - ITV_W'(1);
    end
  end

  AST_TMR_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_i |=> !running_o) else $error("timer survived cancel"); // R4
endmodule

// File: rtl/irqc_dly_fold.sv
module irqc_dly_fold #(
  parameter int unsigned NUM_DLY = 2,
  parameter int unsigned CW      = 32,
  parameter logic [NUM_DLY-1:0][4:0] FOLD_BIT = {5'd0, 5'd7}
) (
  input  logic               fire_i,
  input  logic [NUM_DLY-1:0] busy_i,
  output logic [NUM_DLY-1:0] cancel_o,
  output logic [CW-1:0]      set_o
);
  for (genvar g = 0; g < NUM_DLY; g++) begin : g_fold
    assign cancel_o[g] = fire_i & busy_i[g];
  end

  always_comb begin
    set_o = '0;
    for (int i = 0; i < NUM_DLY; i++) begin
      if (cancel_o[i]) set_o[FOLD_BIT[i]] = 1'b1;
    end
  end
endmodule

// File: rtl/irqc_cause_core.sv
module irqc_cause_core
  import irqc_pkg::*;
#(
  parameter int unsigned ITV_W   = 16,
  parameter int unsigned OVR_BIT = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_valid_i,
  input  logic [IRQ_W-2:0] evt_cause_i,
  input  logic             evt_now_i,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_sel_i,
  input  logic [IRQ_W-1:0] reg_wdata_i,
  input  logic             cause_re_i,
  input  logic             auto_clr_en_i,
  input  logic             tmr_expire_i,
  input  logic             tmr_running_i,
  input  logic [IRQ_W-1:0] fold_set_i,
  output logic             fire_o,
  output logic             tmr_start_o,
  output logic             tmr_cancel_o,
  output logic [ITV_W-1:0] itv_o,
  output logic [IRQ_W-1:0] cause_o,
  output logic [IRQ_W-1:0] mask_o,
  output logic             irq_o
);
  localparam int unsigned LINE = IRQ_W - 1;

  logic [IRQ_W-1:0] cause_q, cause_d, mask_q, mask_d, amask_q, amask_d;
  logic [IRQ_W-1:0] c_v;
  logic [ITV_W-1:0] itv_q, itv_d;
  logic             fire, start, line_v, itv_zero;
  post_res_t        pr_sw, pr_evt;

  assign itv_zero = (itv_q == '0);

  always_comb begin
    c_v     = cause_q;
    mask_d  = mask_q;
    amask_d = amask_q;
    itv_d   = itv_q;
    fire    = 1'b0;
    start   = 1'b0;
    line_v  = 1'b0;
    pr_sw   = '0;
    pr_evt  = '0;

    if (reg_we_i) begin
      case (reg_sel_i)
        OP_W1C:   c_v = c_v & ~reg_wdata_i;
        OP_SET: begin
          pr_sw = post_eval(c_v, mask_d, reg_wdata_i[LINE-1:0],
                            reg_wdata_i[OVR_BIT], itv_zero);
          c_v   = pr_sw.c;
          fire  = fire | pr_sw.fire;
          start = start | pr_sw.start;
        end
        OP_MSET, OP_MCLR: begin
          if (reg_sel_i == OP_MSET) mask_d = mask_d | reg_wdata_i;
          else                      mask_d = mask_d & ~reg_wdata_i;
          if ((c_v[LINE-1:0] & mask_d[LINE-1:0]) == '0) c_v[LINE] = 1'b0;
          // re-evaluate: only an unmasked pending cause may raise the line
          if (!c_v[LINE] && (c_v[LINE-1:0] & mask_d[LINE-1:0]) != '0 && !tmr_running_i) begin
            if (itv_zero) fire  = 1'b1;
            else          start = 1'b1;
          end
        end
        OP_AMASK: amask_d = reg_wdata_i;
        OP_THROT: itv_d   = reg_wdata_i[ITV_W-1:0];
        default: ;
      endcase
    end

    if (cause_re_i) begin
      line_v = c_v[LINE];
      if (line_v) mask_d = mask_d & amask_d;
      if (mask_d == '0 || (line_v && auto_clr_en_i)) c_v = '0;
    end

    if (evt_valid_i) begin
      pr_evt = post_eval(c_v, mask_d, evt_cause_i,
                         evt_now_i | evt_cause_i[OVR_BIT], itv_zero);
      c_v   = pr_evt.c;
      fire  = fire | pr_evt.fire;
      start = start | pr_evt.start;
    end

    if (tmr_expire_i) fire = 1'b1;
  end

  assign cause_d      = fire ? (c_v | fold_set_i | (IRQ_W'(1) << LINE)) : c_v;
  assign fire_o       = fire;
  assign tmr_start_o  = start & ~fire;
  assign tmr_cancel_o = fire;
  assign itv_o        = itv_q;
  assign cause_o      = cause_q;
  assign mask_o       = mask_q;
  assign irq_o        = cause_q[LINE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      mask_q  <= '0;
      amask_q <= '0;
      itv_q   <= '0;
    end else begin
      cause_q <= cause_d;
      mask_q  <= mask_d;
      amask_q <= amask_d;
      itv_q   <= itv_d;
    end
  end

  AST_DUP_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i && !reg_we_i && !cause_re_i && !tmr_expire_i &&
    ((evt_cause_i & cause_q[LINE-1:0]) != '0)
    |=> cause_q == $past(cause_q)) else $error("overlapping post altered causes"); // R1

  AST_PENDING_HOLDS_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i && !reg_we_i && !cause_re_i && !tmr_expire_i &&
    ((cause_q[LINE-1:0] & mask_q[LINE-1:0]) != '0)
    |=> irq_o == $past(irq_o)) else $error("line moved with cause pending"); // R2

  AST_IMM_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i && evt_now_i && !reg_we_i && !cause_re_i && (evt_cause_i != '0) &&
    ((evt_cause_i & cause_q[LINE-1:0]) == '0) &&
    ((cause_q[LINE-1:0] & mask_q[LINE-1:0]) == '0)
    |=> irq_o) else $error("immediate post did not raise line"); // R4

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && (reg_sel_i == OP_W1C) && !evt_valid_i && !cause_re_i && !tmr_expire_i
    |=> (cause_q & $past(reg_wdata_i)) == '0) else $error("cleared bit survived"); // R6

  AST_RD_AUTOCLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_re_i && !reg_we_i && !evt_valid_i && !tmr_expire_i && irq_o && auto_clr_en_i
    |=> cause_q == '0) else $error("read did not clear causes"); // R7

  AST_MASK_DEASSERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && (reg_sel_i == OP_MCLR) && !evt_valid_i && !cause_re_i && !tmr_expire_i &&
    ((cause_q[LINE-1:0] & mask_q[LINE-1:0] & ~reg_wdata_i[LINE-1:0]) == '0)
    |=> !irq_o) else $error("line held with nothing unmasked"); // R8

  AST_NO_EMPTY_REEVAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && ((reg_sel_i == OP_MSET) || (reg_sel_i == OP_MCLR)) && !irq_o &&
    !evt_valid_i && !cause_re_i && !tmr_expire_i
    |=> !irq_o || ((cause_q[LINE-1:0] & mask_q[LINE-1:0]) != '0))
    else $error("mask write raised line with no cause"); // R9
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned TICK_DIV = 51,
  parameter int unsigned ITV_W    = 16,
  parameter int unsigned NUM_DLY  = 2,
  parameter int unsigned OVR_BIT  = 6,
  parameter logic [NUM_DLY-1:0][4:0] FOLD_BIT = {5'd0, 5'd7}
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               evt_valid_i,
  input  logic [30:0]        evt_cause_i,
  input  logic               evt_now_i,
  input  logic               reg_we_i,
  input  logic [2:0]         reg_sel_i,
  input  logic [31:0]        reg_wdata_i,
  input  logic               cause_re_i,
  input  logic               auto_clr_en_i,
  input  logic [NUM_DLY-1:0] dly_busy_i,
  output logic [NUM_DLY-1:0] dly_cancel_o,
  output logic               irq_o,
  output logic [31:0]        cause_rdata_o,
  output logic [31:0]        mask_o
);
  logic             fire, tmr_start, tmr_cancel, tmr_running, tmr_expire;
  logic [ITV_W-1:0] itv;
  logic [IRQ_W-1:0] fold_set;

  irqc_cause_core #(.ITV_W(ITV_W), .OVR_BIT(OVR_BIT)) u_core (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .evt_valid_i   (evt_valid_i),
    .evt_cause_i   (evt_cause_i),
    .evt_now_i     (evt_now_i),
    .reg_we_i      (reg_we_i),
    .reg_sel_i     (reg_sel_i),
    .reg_wdata_i   (reg_wdata_i),
    .cause_re_i    (cause_re_i),
    .auto_clr_en_i (auto_clr_en_i),
    .tmr_expire_i  (tmr_expire),
    .tmr_running_i (tmr_running),
    .fold_set_i    (fold_set),
    .fire_o        (fire),
    .tmr_start_o   (tmr_start),
    .tmr_cancel_o  (tmr_cancel),
    .itv_o         (itv),
    .cause_o       (cause_rdata_o),
    .mask_o        (mask_o),
    .irq_o         (irq_o)
  );

  irqc_throttle_tmr #(.TICK_DIV(TICK_DIV), .ITV_W(ITV_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (tmr_start),
    .cancel_i   (tmr_cancel),
    .interval_i (itv),
    .running_o  (tmr_running),
    .expire_o   (tmr_expire)
  );

  irqc_dly_fold #(.NUM_DLY(NUM_DLY), .CW(IRQ_W), .FOLD_BIT(FOLD_BIT)) u_fold (
    .fire_i   (fire),
    .busy_i   (dly_busy_i),
    .cancel_o (dly_cancel_o),
    .set_o    (fold_set)
  );

  AST_FOLD_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dly_cancel_o != '0) |=> irq_o) else $error("delay cancel without line"); // R5
endmodule

// File: tb/irqc_top_bench.sv
`timescale 1ns/1ps
module irqc_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0, evt_now = 1'b0;
  logic [30:0] evt_cause = '0;
  logic        reg_we = 1'b0, cause_re = 1'b0, auto_clr = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [1:0]  dly_busy = '0;
  logic [1:0]  dly_cancel;
  logic        irq;
  logic [31:0] cause, mask;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irqc_top #(.TICK_DIV(4)) u_irqc_top (
    .clk_i(clk), .rst_ni(rst_n), .evt_valid_i(evt_valid), .evt_cause_i(evt_cause),
    .evt_now_i(evt_now), .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .cause_re_i(cause_re), .auto_clr_en_i(auto_clr), .dly_busy_i(dly_busy),
    .dly_cancel_o(dly_cancel), .irq_o(irq), .cause_rdata_o(cause), .mask_o(mask)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic post(input logic [30:0] c, input logic now);
    @(negedge clk);
    evt_valid = 1'b1; evt_cause = c; evt_now = now;
    @(negedge clk);
    evt_valid = 1'b0; evt_cause = '0; evt_now = 1'b0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
  endtask

  task automatic rd(input string req, input logic [31:0] exp);
    @(negedge clk);
    cause_re = 1'b1;
    #1 chk(req, cause, exp);
    @(negedge clk);
    cause_re = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 cause", cause, 32'h0);
    chk("R10 mask", mask, 32'h0);
    chk("R10 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_immediate;
    post(31'h4, 1'b0);
    chk("R3 cause", cause, 32'h8000_0004);
    chk("R3 irq", {31'b0, irq}, 32'h1);
    wr(3'd0, 32'h8000_0004);
    chk("R6 w1c cause", cause, 32'h0);
    chk("R6 w1c irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_dup;
    post(31'h4, 1'b0);
    post(31'hC, 1'b0);
    chk("R1 overlap ignored", cause, 32'h8000_0004);
    wr(3'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_mask;
    wr(3'd2, 32'h4);
    chk("R9 no cause no line", {31'b0, irq}, 32'h0);
    chk("R8 mask set", mask, 32'h4);
    post(31'h4, 1'b0);
    wr(3'd0, 32'h8000_0000);
    chk("R6 line only cleared", cause, 32'h4);
    post(31'h10, 1'b0);
    chk("R2 pending OR only", cause, 32'h14);
    wr(3'd3, 32'h4);
    chk("R8 mask clr", mask, 32'h0);
    wr(3'd2, 32'h10);
    chk("R9 reeval raises", cause, 32'h8000_0014);
    wr(3'd3, 32'h10);
    chk("R8 deassert on clr", cause, 32'h14);
    wr(3'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_throttle;
    wr(3'd5, 32'd5);
    post(31'h2, 1'b0);
    repeat (17) @(negedge clk);
    chk("R4 not yet", cause, 32'h2);
    repeat (4) @(negedge clk);
    chk("R4 throttled fire", cause, 32'h8000_0002);
    wr(3'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_override;
    post(31'h2, 1'b0);
    repeat (3) @(negedge clk);
    chk("R4 waiting", {31'b0, irq}, 32'h0);
    post(31'h8, 1'b1);
    chk("R4 immediate override", cause, 32'h8000_000A);
    wr(3'd0, 32'hFFFF_FFFF);
    repeat (25) @(negedge clk);
    chk("R4 timer cancelled", cause, 32'h0);
    post(31'h40, 1'b0);
    chk("R4 overrun immediate", cause, 32'h8000_0040);
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd5, 32'd0);
  endtask

  task automatic t_fold;
    @(negedge clk);
    dly_busy = 2'b11; evt_valid = 1'b1; evt_cause = 31'h4;
    #1 chk("R5 cancel pulse", {30'b0, dly_cancel}, 32'h3);
    @(negedge clk);
    evt_valid = 1'b0; evt_cause = '0;
    chk("R5 folded causes", cause, 32'h8000_0085);
    chk("R5 no pulse after", {30'b0, dly_cancel}, 32'h0);
    dly_busy = 2'b00;
    wr(3'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_read;
    wr(3'd4, 32'hFFFF_FFFB);
    wr(3'd2, 32'h6);
    post(31'h4, 1'b0);
    rd("R7 read data", 32'h8000_0004);
    chk("R7 automask applied", mask, 32'h2);
    chk("R7 kept causes", cause, 32'h8000_0004);
    auto_clr = 1'b1;
    rd("R7 read data 2", 32'h8000_0004);
    chk("R7 auto clear", cause, 32'h0);
    auto_clr = 1'b0;
    wr(3'd3, 32'hFFFF_FFFF);
    post(31'h1, 1'b0);
    rd("R7 read data 3", 32'h8000_0001);
    chk("R7 zero mask clear", cause, 32'h0);
  endtask

  task automatic t_sw_and_noop;
    wr(3'd1, 32'h20);
    chk("R11 sw set", cause, 32'h8000_0020);
    wr(3'd1, 32'h30);
    chk("R11 sw overlap ignored", cause, 32'h8000_0020);
    wr(3'd0, 32'hFFFF_FFFF);
    post(31'h0, 1'b0);
    chk("R12 zero post", cause, 32'h0);
    wr(3'd6, 32'hFFFF_FFFF);
    chk("R12 sel6 cause", cause, 32'h0);
    chk("R12 sel6 mask", mask, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_immediate();
    t_dup();
    t_mask();
    t_throttle();
    t_override();
    t_fold();
    t_read();
    t_sw_and_noop();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule